// File: doc/BRIEF.md
# Shared RAM Two-Port Access Arbiter

This block owns a 1 KB synchronous RAM that two masters share: a local processor port and a slave port on the system bus. Each side drives a request together with an address, a write enable and write data. It holds all of them until the block answers with a one-cycle ready pulse, and in that ready cycle it drops or changes them. The RAM performs one access per clock. The block picks which port uses each RAM cycle.

The two sides see the RAM at different addresses. On the system side the RAM appears in a 1 KB window whose index comes from a configuration input. On the local side it sits at a fixed base, and that base moves higher when an expansion strap is set. System accesses always finish with one wait state. A system request that loses a contested cycle is served in the next cycle, so only the local side sees extra wait states. Either side can hold a lock across a read-modify-write sequence. While that lock is held, the other side is kept off the RAM.

Top module: `dpa_arbiter`

## Requirements
- R1: A system request hits the RAM only when sys_addr_i[19:10] equals cfg_sys_base_i. The RAM offset is the address bits [9:0]. Both ports reach the same byte at the same offset.
- R2: An accepted system request sees sys_rdy_o high for exactly one cycle. That cycle is the second after the one in which the request first appears. On a read, sys_rdata_o holds the byte during that cycle.
- R3: The local window is 0x00C00 to 0x00FFF when exp_strap_i is 0 and 0x01C00 to 0x01FFF when exp_strap_i is 1. Addresses are on 20 bits.
- R4: An uncontested local request sees loc_rdy_o for one cycle, two cycles after it first appears. A local request that loses a contested RAM cycle is answered one cycle later.
- R5: When new requests from both ports first appear in the same cycle and neither port carries a lock, the system port wins the first such contest after reset. After that the winner alternates from contest to contest.
- R6: Once a local access has been made with loc_lock_i high, no system request is answered for as long as loc_lock_i stays high. The blocked system request is answered two cycles after loc_lock_i falls.
- R7: The same holds with the sides swapped: sys_lock_i excludes local accesses, and the blocked local request is answered two cycles after sys_lock_i falls.
- R8: The port holding a lock keeps the uncontested two-cycle timing for each of its consecutive accesses while the other port is waiting.
- R9: A request outside its port's window is ignored. It never receives ready, and a write it carries leaves the RAM unchanged.
- R10: Reset drives both ready outputs low and clears any held lock and the contest history. The first contest after reset goes to the system port again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sys_base_i | input | 10 | 1 KB window index on the system side |
| exp_strap_i | input | 1 | Moves the local base from 3K to 7K |
| loc_req_i | input | 1 | Local access request |
| loc_addr_i | input | 20 | Local byte address |
| loc_we_i | input | 1 | Local write enable |
| loc_wdata_i | input | 8 | Local write data |
| loc_lock_i | input | 1 | Local lock |
| loc_rdy_o | output | 1 | Local ready pulse |
| loc_rdata_o | output | 8 | Local read data, valid with ready |
| sys_req_i | input | 1 | System access request |
| sys_addr_i | input | 20 | System byte address |
| sys_we_i | input | 1 | System write enable |
| sys_wdata_i | input | 8 | System write data |
| sys_lock_i | input | 1 | System lock |
| sys_rdy_o | output | 1 | System ready pulse |
| sys_rdata_o | output | 8 | System read data, valid with ready |

## Verification
Two things can fall in the same cycle. A new request can arrive on both ports at once, and a lock can be taken or released while the other port is already waiting. The bench starts both requests on the same clock edge in successive contests, including one right after a reset. It checks each port's ready latency against the contest winner that it predicts with its own alternating flag, and it checks read data on both ports, including a system read that completes one cycle after the local port has overwritten the RAM output register. For locks, the bench drops the lock at a recorded cycle and requires the blocked port's ready exactly two cycles later.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_LOC  = 2'd1,
    LK_SYS  = 2'd2
  } lock_own_e;
endpackage

// File: rtl/dpa_win_dec.sv
module dpa_win_dec #(
  parameter int AW     = 20,
  parameter int RAM_AW = 10,
  localparam int WW    = AW - RAM_AW
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [WW-1:0]     base_i,
  output logic              hit_o,
  output logic [RAM_AW-1:0] offs_o
);
  assign hit_o  = (addr_i[AW-1:RAM_AW] == base_i);
  assign offs_o = addr_i[RAM_AW-1:0];
endmodule

// File: rtl/dpa_ram.sv
module dpa_ram #(
  parameter int DW     = 8,
  parameter int RAM_AW = 10,
  localparam int DEPTH = 1 << RAM_AW
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [RAM_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      rd_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/dpa_slot_arb.sv
module dpa_slot_arb
  import dpa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_new_i,
  input  logic sys_force_i,
  input  logic loc_new_i,
  input  logic loc_lock_i,
  input  logic sys_lock_i,
  output logic g_sys_o,
  output logic g_loc_o,
  output logic loc_holds_o,
  output logic sys_holds_o
);
  lock_own_e lock_q, lock_d;
  logic      tie_sys_q;
  logic      contest;

  assign loc_holds_o = (lock_q == LK_LOC) && loc_lock_i;
  assign sys_holds_o = (lock_q == LK_SYS) && sys_lock_i;
  assign contest     = sys_new_i && loc_new_i && !sys_force_i;

  always_comb begin
    g_sys_o = 1'b0;
    g_loc_o = 1'b0;
    if (sys_force_i) begin
      g_sys_o = 1'b1;               // deferred system access must go now
    end else if (contest) begin
      if (loc_lock_i)      g_sys_o = 1'b1;  // a locking local access yields
      else if (sys_lock_i) g_loc_o = 1'b1;
      else if (tie_sys_q)  g_loc_o = 1'b1;
      else                 g_sys_o = 1'b1;
    end else if (sys_new_i) begin
      g_sys_o = 1'b1;
    end else if (loc_new_i) begin
      g_loc_o = 1'b1;
    end
  end

  always_comb begin
    lock_d = lock_q;
    if (lock_q == LK_LOC && !loc_lock_i) lock_d = LK_NONE;
    if (lock_q == LK_SYS && !sys_lock_i) lock_d = LK_NONE;
    if (lock_d == LK_NONE) begin
      if (g_loc_o && loc_lock_i)      lock_d = LK_LOC;
      else if (g_sys_o && sys_lock_i) lock_d = LK_SYS;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= LK_NONE;
      tie_sys_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
      if (contest && !loc_lock_i && !sys_lock_i) tie_sys_q <= g_sys_o;
    end
  end

  // R5
  one_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({g_sys_o, g_loc_o}));
  // R6
  loc_lock_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_holds_o |-> !g_sys_o);
  // R7
  sys_lock_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_holds_o |-> !g_loc_o);
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter #(
  parameter int DW           = 8,
  parameter int RAM_AW       = 10,
  parameter int LOC_AW       = 20,
  parameter int SYS_AW       = 20,
  parameter int LOC_BASE_IDX = 3,
  parameter int LOC_EXP_IDX  = 7,
  localparam int SYS_WW      = SYS_AW - RAM_AW,
  localparam int LOC_WW      = LOC_AW - RAM_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SYS_WW-1:0] cfg_sys_base_i,
  input  logic              exp_strap_i,
  input  logic              loc_req_i,
  input  logic [LOC_AW-1:0] loc_addr_i,
  input  logic              loc_we_i,
  input  logic [DW-1:0]     loc_wdata_i,
  input  logic              loc_lock_i,
  output logic              loc_rdy_o,
  output logic [DW-1:0]     loc_rdata_o,
  input  logic              sys_req_i,
  input  logic [SYS_AW-1:0] sys_addr_i,
  input  logic              sys_we_i,
  input  logic [DW-1:0]     sys_wdata_i,
  input  logic              sys_lock_i,
  output logic              sys_rdy_o,
  output logic [DW-1:0]     sys_rdata_o
);
  logic [LOC_WW-1:0] loc_base;
  logic              sys_hit, loc_hit;
  logic [RAM_AW-1:0] sys_offs, loc_offs;
  logic              sys_new, loc_new, g_sys, g_loc, loc_holds, sys_holds;
  logic              sys_wait_q, sys_done_q, sys_rdy_q, loc_done_q, loc_rdy_q;
  logic              op_vld_q, op_sys_q;
  logic [DW-1:0]     mem_rd, sys_hold_q, loc_hold_q;

  assign loc_base = exp_strap_i ? LOC_WW'(LOC_EXP_IDX) : LOC_WW'(LOC_BASE_IDX);

  dpa_win_dec #(.AW(SYS_AW), .RAM_AW(RAM_AW)) u_sys_dec (
    .addr_i(sys_addr_i), .base_i(cfg_sys_base_i), .hit_o(sys_hit), .offs_o(sys_offs)
  );
  dpa_win_dec #(.AW(LOC_AW), .RAM_AW(RAM_AW)) u_loc_dec (
    .addr_i(loc_addr_i), .base_i(loc_base), .hit_o(loc_hit), .offs_o(loc_offs)
  );

  // a request still high in its ready cycle is the finished access, not a new one
  assign sys_new = sys_req_i && sys_hit && !sys_rdy_q && !sys_wait_q && !sys_done_q && !loc_holds;
  assign loc_new = loc_req_i && loc_hit && !loc_rdy_q && !loc_done_q && !sys_holds;

  dpa_slot_arb u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_new_i  (sys_new),
    .sys_force_i(sys_wait_q),
    .loc_new_i  (loc_new),
    .loc_lock_i (loc_lock_i),
    .sys_lock_i (sys_lock_i),
    .g_sys_o    (g_sys),
    .g_loc_o    (g_loc),
    .loc_holds_o(loc_holds),
    .sys_holds_o(sys_holds)
  );

  dpa_ram #(.DW(DW), .RAM_AW(RAM_AW)) u_ram (
    .clk_i  (clk_i),
    .en_i   (g_sys | g_loc),
    .we_i   (g_sys ? sys_we_i : loc_we_i),
    .addr_i (g_sys ? sys_offs : loc_offs),
    .wdata_i(g_sys ? sys_wdata_i : loc_wdata_i),
    .rdata_o(mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_wait_q <= 1'b0;
      sys_done_q <= 1'b0;
      sys_rdy_q  <= 1'b0;
      loc_done_q <= 1'b0;
      loc_rdy_q  <= 1'b0;
      op_vld_q   <= 1'b0;
      op_sys_q   <= 1'b0;
      sys_hold_q <= '0;
      loc_hold_q <= '0;
    end else begin
      sys_wait_q <= sys_new && !g_sys;
      sys_done_q <= sys_new && g_sys;
      sys_rdy_q  <= sys_done_q || sys_wait_q;
      loc_done_q <= g_loc;
      loc_rdy_q  <= loc_done_q;
      op_vld_q   <= g_sys || g_loc;
      op_sys_q   <= g_sys;
      if (op_vld_q && op_sys_q)  sys_hold_q <= mem_rd;
      if (op_vld_q && !op_sys_q) loc_hold_q <= mem_rd;
    end
  end

  // RAM output register belongs to the latest access; older results come from the holds
  assign sys_rdata_o = (op_vld_q && op_sys_q)  ? mem_rd : sys_hold_q;
  assign loc_rdata_o = (op_vld_q && !op_sys_q) ? mem_rd : loc_hold_q;
  assign sys_rdy_o   = sys_rdy_q;
  assign loc_rdy_o   = loc_rdy_q;

  // R2
  sys_one_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rdy_o |-> $past(sys_new, 2));
  // R2
  sys_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rdy_o |=> !sys_rdy_o);
  // R4
  loc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_rdy_o |=> !loc_rdy_o);
  // R9
  sys_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_hit |-> !g_sys || sys_wait_q);
  // R9
  loc_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_hit |-> !g_loc);
endmodule

// File: tb/dpa_arbiter_tb.sv
module dpa_arbiter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  cfg_base = '0;
  logic        strap = 1'b0;
  logic        loc_req = 1'b0, loc_we = 1'b0, loc_lock = 1'b0;
  logic [19:0] loc_addr = '0;
  logic [7:0]  loc_wd = '0;
  logic        sys_req = 1'b0, sys_we = 1'b0, sys_lock = 1'b0;
  logic [19:0] sys_addr = '0;
  logic [7:0]  sys_wd = '0;
  logic        loc_rdy, sys_rdy;
  logic [7:0]  loc_rd, sys_rd;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] model [1024];
  bit tflag = 1'b0;
  int ls, ll, d_cyc, s_cyc;
  logic [7:0] rs, rl;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  dpa_arbiter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_sys_base_i(cfg_base), .exp_strap_i(strap),
    .loc_req_i(loc_req), .loc_addr_i(loc_addr), .loc_we_i(loc_we), .loc_wdata_i(loc_wd),
    .loc_lock_i(loc_lock), .loc_rdy_o(loc_rdy), .loc_rdata_o(loc_rd),
    .sys_req_i(sys_req), .sys_addr_i(sys_addr), .sys_we_i(sys_we), .sys_wdata_i(sys_wd),
    .sys_lock_i(sys_lock), .sys_rdy_o(sys_rdy), .sys_rdata_o(sys_rd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // called at a negedge; drives, waits for ready, drops, then checks the pulse ended
  task automatic acc(input bit s, input logic [19:0] a, input bit w, input logic [7:0] d,
                     input int maxc, input string tag, output int lat, output logic [7:0] rd);
    lat = -1; rd = '0;
    if (s) begin sys_req = 1; sys_addr = a; sys_we = w; sys_wd = d; end
    else   begin loc_req = 1; loc_addr = a; loc_we = w; loc_wd = d; end
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk_i);
      if (s ? sys_rdy : loc_rdy) begin
        lat = i; rd = s ? sys_rd : loc_rd;
        break;
      end
    end
    if (s) sys_req = 0; else loc_req = 0;
    @(negedge clk_i);
    if (lat > 0) chk({tag, " pulse"}, int'(s ? sys_rdy : loc_rdy), 0);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    chk("R10 loc_rdy in reset", int'(loc_rdy), 0);
    chk("R10 sys_rdy in reset", int'(sys_rdy), 0);
    rst_ni = 1;
    tflag = 0;
    @(negedge clk_i);
  endtask

  task automatic tie_read(input int so, input int lo);
    bit sw;
    sw = !tflag;
    tflag = sw;
    fork
      acc(1, {cfg_base, 10'(so)}, 0, 0, 10, "R5", ls, rs);
      acc(0, 20'(3*1024 + lo), 0, 0, 10, "R5", ll, rl);
    join
    chk("R5 sys latency in contest", ls, 2);
    chk("R4 loc latency in contest", ll, sw ? 3 : 2);
    chk("R5 sys read data", int'(rs), int'(model[so]));
    chk("R5 loc read data", int'(rl), int'(model[lo]));
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lat;
    logic [7:0] rd;
    int bases [6] = '{0, 1, 3, 7, 512, 1023};
    @(negedge clk_i);
    do_reset();

    // R1 R2 R3 R4: sweep of system windows, read back through the local side
    foreach (bases[b]) begin
      cfg_base = 10'(bases[b]);
      for (int o = 0; o < 1024; o += 61) begin
        logic [7:0] v;
        v = 8'((o * 7 + bases[b]) & 255);
        acc(1, {cfg_base, 10'(o)}, 1, v, 8, "R2", lat, rd);
        chk("R2 sys write latency", lat, 2);
        model[o] = v;
        acc(0, 20'(3*1024 + o), 0, 0, 8, "R4", lat, rd);
        chk("R4 loc read latency", lat, 2);
        chk("R1 shared byte", int'(rd), int'(v));
        acc(1, {cfg_base, 10'(o)}, 0, 0, 8, "R2", lat, rd);
        chk("R2 sys read data", int'(rd), int'(v));
      end
    end

    // R3: strap relocation
    strap = 1;
    for (int o = 0; o < 1024; o += 255) begin
      acc(0, 20'(7*1024 + o), 0, 0, 8, "R3", lat, rd);
      chk("R3 relocated latency", lat, 2);
      chk("R3 relocated data", int'(rd), int'(model[o]));
    end
    acc(0, 20'(3*1024), 0, 0, 8, "R3", lat, rd);
    chk("R3 old base ignored with strap", lat, -1);
    strap = 0;
    acc(0, 20'(7*1024), 0, 0, 8, "R3", lat, rd);
    chk("R3 high base ignored without strap", lat, -1);

    // R9: out-of-window writes change nothing
    cfg_base = 10'd5;
    acc(1, {10'd6, 10'd0}, 1, 8'hAA, 8, "R9", lat, rd);
    chk("R9 sys miss no ready", lat, -1);
    acc(0, 20'(7*1024), 1, 8'h55, 8, "R9", lat, rd);
    chk("R9 loc miss no ready", lat, -1);
    acc(0, 20'(3*1024), 0, 0, 8, "R9", lat, rd);
    chk("R9 RAM untouched", int'(rd), int'(model[0]));

    // R5: contests
    acc(1, {cfg_base, 10'd100}, 1, 8'h5A, 8, "R2", lat, rd); model[100] = 8'h5A;
    acc(1, {cfg_base, 10'd200}, 1, 8'hC3, 8, "R2", lat, rd); model[200] = 8'hC3;
    do_reset();
    tie_read(100, 200);
    tie_read(200, 100);
    tie_read(100, 100);
    // R10: contest history cleared
    do_reset();
    tie_read(200, 200);

    // R6 R8: local lock
    loc_lock = 1;
    acc(0, 20'(3*1024 + 300), 1, 8'h3C, 8, "R8", lat, rd); model[300] = 8'h3C;
    chk("R8 locking access latency", lat, 2);
    s_cyc = cyc;
    fork
      acc(1, {cfg_base, 10'd300}, 0, 0, 60, "R6", ls, rs);
      begin
        repeat (4) @(negedge clk_i);
        acc(0, 20'(3*1024 + 301), 1, 8'h77, 8, "R8", lat, rd); model[301] = 8'h77;
        chk("R8 locked access 2 latency", lat, 2);
        acc(0, 20'(3*1024 + 300), 0, 0, 8, "R8", lat, rd);
        chk("R8 locked access 3 latency", lat, 2);
        chk("R8 locked read data", int'(rd), 8'h3C);
        repeat (3) @(negedge clk_i);
        d_cyc = cyc;
        loc_lock = 0;
      end
    join
    chk("R6 sys answered two cycles after release", ls, d_cyc + 2 - s_cyc);
    chk("R6 sys read data", int'(rs), 8'h3C);

    // R7: system lock
    sys_lock = 1;
    acc(1, {cfg_base, 10'd302}, 1, 8'h96, 8, "R7", lat, rd); model[302] = 8'h96;
    chk("R7 locking access latency", lat, 2);
    s_cyc = cyc;
    fork
      acc(0, 20'(3*1024 + 302), 0, 0, 60, "R7", ll, rl);
      begin
        repeat (3) @(negedge clk_i);
        acc(1, {cfg_base, 10'd303}, 1, 8'h11, 8, "R8", lat, rd); model[303] = 8'h11;
        chk("R8 sys locked access latency", lat, 2);
        repeat (2) @(negedge clk_i);
        d_cyc = cyc;
        sys_lock = 0;
      end
    join
    chk("R7 loc answered two cycles after release", ll, d_cyc + 2 - s_cyc);
    chk("R7 loc read data", int'(rl), 8'h96);

    // R10: reset drops a held lock
    loc_lock = 1;
    acc(0, 20'(3*1024 + 303), 0, 0, 8, "R10", lat, rd);
    do_reset();
    acc(1, {cfg_base, 10'd303}, 0, 0, 8, "R10", lat, rd);
    chk("R10 lock cleared by reset", lat, 2);
    chk("R10 data survives", int'(rd), 8'h11);
    loc_lock = 0;

    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule